// File: doc/BRIEF.md
# Dual-Port PHY Power-Up Sequencer

This block takes two serial-link PHY ports from a fully held state to running, one step at a time in a fixed order, with no software involved. A one-cycle `start_i` pulse begins the run. Every active-low power-down and reset control of both ports is pulled low. The power-down controls are released first. The two power-on resets follow one after the other. Control then passes to an external PHY configuration engine through a start/done handshake. After that the lane and synthesizer hard resets are released. Last, the timer-scale override is set and the link core is let out of reset along with its bus low-power request lines.

All delays are counted in microsecond ticks. A prescaler divides the clock by `CLKS_PER_US` to make those ticks, so a fast simulation can shorten every wait by changing parameters. When the link core is running, the block samples the two ready inputs. It samples once straight away and then once after every poll interval. It stops as soon as both ports are ready, or after `POLL_MAX` samples. It then reports an up/down bit for each port and pulses `done_o`.

States, in order: `ST_IDLE` →(start) `ST_PD_HOLD` →(hold expired) `ST_PD_SETTLE` →(expired) `ST_POR0_WAIT` →(expired) `ST_POR1_WAIT` →(expired) `ST_CFG_HANDOFF` →(cfg_done) `ST_CFG_SETTLE` →(expired) `ST_HRST_WAIT` →(expired) `ST_TSCALE_SET` →(always) `ST_CORE_RELEASE` →(always) `ST_POLL_CHK` →(both ready or last sample) `ST_FINISH`, else →`ST_POLL_GAP` →(expired) `ST_POLL_CHK`. `ST_FINISH` →(always) `ST_IDLE`.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, all twelve port controls, `tscale_ovr_o`, `core_rst_n_o`, both low-power requests, `cfg_start_o`, `done_o`, `busy_o` and `port_up_o` are 0.
- R2: In the clock edge that accepts `start_i` while idle, all twelve port controls and the core-side outputs go low, and `busy_o` goes high.
- R3: `RST_HOLD_US` ticks after start, the TX, RX and synthesizer power-down controls of both ports rise to 1 together, while every reset stays low.
- R4: `STEP_US` ticks after the power-down release, `por_n_o[0]` rises. `STEP_US` ticks after that, `por_n_o[1]` rises. Port 1 is never out of power-on reset while port 0 is still in it.
- R5: `STEP_US` ticks after `por_n_o[1]` rises, `cfg_start_o` is high for exactly one cycle. The hard resets stay low until `cfg_done_i` is seen, however long that takes.
- R6: `STEP_US` ticks after the edge that samples `cfg_done_i`, the lane and synthesizer hard resets of both ports rise together. They never rise while a power-on reset is still low.
- R7: `RST_HOLD_US` ticks after the hard-reset release, `tscale_ovr_o` rises. One cycle later, `core_rst_n_o`, `mst_lp_req_o` and `slv_lp_req_o` rise together.
- R8: The ready inputs are sampled one cycle after the core release, and then every `POLL_US` ticks plus one cycle. If a sample finds both ports ready, the sequence ends at that sample's edge.
- R9: If both ports are not ready by the `POLL_MAX`-th sample, the sequence ends at that sample. `port_up_o[i]` is the ready level of port i at the final sample (1 = up).
- R10: `done_o` is high for exactly one cycle, at the edge where the final sample is taken. `busy_o` is low on the following cycle.
- R11: A `start_i` pulse while the sequence is busy has no effect: every later step keeps its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the sequence (accepted only when idle) |
| cfg_done_i | input | 1 | External configuration engine finished |
| phy_ready_i | input | 2 | Per-port PHY ready |
| cfg_start_o | output | 1 | One-cycle request to the configuration engine |
| por_n_o | output | 2 | Per-port power-on reset, active low |
| lane_rst_n_o | output | 2 | Per-port lane hard reset, active low |
| synth_rst_n_o | output | 2 | Per-port synthesizer hard reset, active low |
| txpd_n_o | output | 2 | Per-port TX lane power-down, active low |
| rxpd_n_o | output | 2 | Per-port RX lane power-down, active low |
| synthpd_n_o | output | 2 | Per-port synthesizer power-down, active low |
| tscale_ovr_o | output | 1 | Timer-scale override |
| core_rst_n_o | output | 1 | Link-core reset, active low |
| mst_lp_req_o | output | 1 | Bus master low-power request |
| slv_lp_req_o | output | 1 | Bus slave low-power request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| port_up_o | output | 2 | Per-port result, 1 = up |

## Verification
Every timed step is due exactly N × `CLKS_PER_US` cycles after the edge of the step before it. The bench records, at each falling edge, the rising-edge count at which each output first shows its new level, and compares the differences with those products. The two steps with no timer are checked at fixed distances: the core release follows the override by exactly one cycle, and `done_o` is due 2 + k × (`POLL_US` × `CLKS_PER_US` + 1) cycles after the core release for the k-th sample. The bench computes k from the cycle at which it raised each ready input. Ready onset is swept across every sample window for all four port masks, and the configuration handshake delay is varied across runs.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int NPORT = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PD_HOLD,
        ST_PD_SETTLE,
        ST_POR0_WAIT,
        ST_POR1_WAIT,
        ST_CFG_HANDOFF,
        ST_CFG_SETTLE,
        ST_HRST_WAIT,
        ST_TSCALE_SET,
        ST_CORE_RELEASE,
        ST_POLL_CHK,
        ST_POLL_GAP,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/us_prescaler.sv
// Divides the clock down to one tick per microsecond; restart realigns phase.
module us_prescaler #(
    parameter int CLKS_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PW-1:0] TOP = PW'(CLKS_PER_US - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart_i) begin
            cnt <= TOP;
        end else if (cnt == '0) begin
            cnt <= TOP;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick_o = (cnt == '0);

    // R3
    prescale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);

endmodule

// File: rtl/us_delay.sv
// Counts microsecond ticks down from a loaded value; expires on the last tick.
module us_delay #(
    parameter int US_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [US_W-1:0] load_val_i,
    input  logic            tick_i,
    output logic            expired_o
);
    logic [US_W-1:0] us_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            us_left <= '0;
        end else if (load_i) begin
            us_left <= load_val_i - 1'b1;
        end else if (tick_i && (us_left != '0)) begin
            us_left <= us_left - 1'b1;
        end
    end

    assign expired_o = tick_i && (us_left == '0);

    // R4
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (load_val_i != '0));

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
    import phy_seq_pkg::*;
#(
    parameter int CLKS_PER_US = 50,
    parameter int RST_HOLD_US = 300,
    parameter int STEP_US     = 1000,
    parameter int POLL_US     = 10,
    parameter int POLL_MAX    = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       cfg_done_i,
    input  logic [1:0] phy_ready_i,
    output logic       cfg_start_o,
    output logic [1:0] por_n_o,
    output logic [1:0] lane_rst_n_o,
    output logic [1:0] synth_rst_n_o,
    output logic [1:0] txpd_n_o,
    output logic [1:0] rxpd_n_o,
    output logic [1:0] synthpd_n_o,
    output logic       tscale_ovr_o,
    output logic       core_rst_n_o,
    output logic       mst_lp_req_o,
    output logic       slv_lp_req_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] port_up_o
);
    localparam int MAX_A  = (RST_HOLD_US > STEP_US) ? RST_HOLD_US : STEP_US;
    localparam int MAX_US = (MAX_A > POLL_US) ? MAX_A : POLL_US;
    localparam int US_W   = $clog2(MAX_US + 1);
    localparam int PC_W   = $clog2(POLL_MAX + 1);
    localparam logic [PC_W-1:0] LAST_POLL = PC_W'(POLL_MAX - 1);

    seq_state_e      state, nxt;
    logic            enter;
    logic            tick;
    logic            expired;
    logic [US_W-1:0] load_val;
    logic [PC_W-1:0] poll_cnt;
    logic            all_ready;

    assign all_ready = &phy_ready_i;
    assign enter     = (nxt != state);

    // Delay length for the state about to be entered.
    always_comb begin
        unique case (nxt)
            ST_PD_HOLD, ST_HRST_WAIT:                       load_val = US_W'(RST_HOLD_US);
            ST_PD_SETTLE, ST_POR0_WAIT, ST_POR1_WAIT,
            ST_CFG_SETTLE:                                  load_val = US_W'(STEP_US);
            ST_POLL_GAP:                                    load_val = US_W'(POLL_US);
            default:                                        load_val = US_W'(1);
        endcase
    end

    us_prescaler #(
        .CLKS_PER_US(CLKS_PER_US)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (enter),
        .tick_o    (tick)
    );

    us_delay #(
        .US_W(US_W)
    ) u_dly (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (enter),
        .load_val_i (load_val),
        .tick_i     (tick),
        .expired_o  (expired)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:         if (start_i)    nxt = ST_PD_HOLD;
            ST_PD_HOLD:      if (expired)    nxt = ST_PD_SETTLE;
            ST_PD_SETTLE:    if (expired)    nxt = ST_POR0_WAIT;
            ST_POR0_WAIT:    if (expired)    nxt = ST_POR1_WAIT;
            ST_POR1_WAIT:    if (expired)    nxt = ST_CFG_HANDOFF;
            ST_CFG_HANDOFF:  if (cfg_done_i) nxt = ST_CFG_SETTLE;
            ST_CFG_SETTLE:   if (expired)    nxt = ST_HRST_WAIT;
            ST_HRST_WAIT:    if (expired)    nxt = ST_TSCALE_SET;
            ST_TSCALE_SET:                   nxt = ST_CORE_RELEASE;
            ST_CORE_RELEASE:                 nxt = ST_POLL_CHK;
            ST_POLL_CHK: begin
                if (all_ready || (poll_cnt == LAST_POLL)) nxt = ST_FINISH;
                else                                      nxt = ST_POLL_GAP;
            end
            ST_POLL_GAP:     if (expired)    nxt = ST_POLL_CHK;
            ST_FINISH:                       nxt = ST_IDLE;
            default:                         nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Poll sample counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_cnt <= '0;
        end else if (enter && (nxt == ST_CORE_RELEASE)) begin
            poll_cnt <= '0;
        end else if ((state == ST_POLL_CHK) && (nxt == ST_POLL_GAP)) begin
            poll_cnt <= poll_cnt + 1'b1;
        end
    end

    // Registered outputs, updated on state entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_start_o   <= 1'b0;
            done_o        <= 1'b0;
            por_n_o       <= '0;
            lane_rst_n_o  <= '0;
            synth_rst_n_o <= '0;
            txpd_n_o      <= '0;
            rxpd_n_o      <= '0;
            synthpd_n_o   <= '0;
            tscale_ovr_o  <= 1'b0;
            core_rst_n_o  <= 1'b0;
            mst_lp_req_o  <= 1'b0;
            slv_lp_req_o  <= 1'b0;
            port_up_o     <= '0;
        end else begin
            cfg_start_o <= 1'b0;
            done_o      <= 1'b0;
            if (enter) begin
                unique case (nxt)
                    ST_PD_HOLD: begin
                        por_n_o       <= '0;
                        lane_rst_n_o  <= '0;
                        synth_rst_n_o <= '0;
                        txpd_n_o      <= '0;
                        rxpd_n_o      <= '0;
                        synthpd_n_o   <= '0;
                        tscale_ovr_o  <= 1'b0;
                        core_rst_n_o  <= 1'b0;
                        mst_lp_req_o  <= 1'b0;
                        slv_lp_req_o  <= 1'b0;
                        port_up_o     <= '0;
                    end
                    ST_PD_SETTLE: begin
                        txpd_n_o    <= '1;
                        rxpd_n_o    <= '1;
                        synthpd_n_o <= '1;
                    end
                    ST_POR0_WAIT:   por_n_o[0] <= 1'b1;
                    ST_POR1_WAIT:   por_n_o[1] <= 1'b1;
                    ST_CFG_HANDOFF: cfg_start_o <= 1'b1;
                    ST_HRST_WAIT: begin
                        lane_rst_n_o  <= '1;
                        synth_rst_n_o <= '1;
                    end
                    ST_TSCALE_SET:  tscale_ovr_o <= 1'b1;
                    ST_CORE_RELEASE: begin
                        core_rst_n_o <= 1'b1;
                        mst_lp_req_o <= 1'b1;
                        slv_lp_req_o <= 1'b1;
                    end
                    ST_FINISH: begin
                        port_up_o <= phy_ready_i;
                        done_o    <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy_o = (state != ST_IDLE);

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i) |=> (por_n_o == 2'b00 && txpd_n_o == 2'b00 && !core_rst_n_o && busy_o));

    // R3
    pd_before_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|por_n_o) |-> ((&txpd_n_o) && (&rxpd_n_o) && (&synthpd_n_o)));

    // R4
    por_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_n_o[1] |-> por_n_o[0]);

    // R5
    cfg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start_o |=> !cfg_start_o);

    // R6
    hrst_after_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lane_rst_n_o) || (|synth_rst_n_o)) |-> (&por_n_o));

    // R7
    tscale_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_n_o |-> tscale_ovr_o);

    // R8
    early_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL_CHK && all_ready) |=> done_o);

    // R9
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= LAST_POLL);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

endmodule

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb_top;

    localparam int CPU  = 2;
    localparam int HOLD = 3;
    localparam int STEP = 5;
    localparam int POLL = 2;
    localparam int PMAX = 4;
    localparam int PER  = POLL * CPU + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       cfg_done_i = 1'b0;
    logic [1:0] phy_ready_i = 2'b00;
    logic       cfg_start_o;
    logic [1:0] por_n_o, lane_rst_n_o, synth_rst_n_o, txpd_n_o, rxpd_n_o, synthpd_n_o;
    logic       tscale_ovr_o, core_rst_n_o, mst_lp_req_o, slv_lp_req_o;
    logic       busy_o, done_o;
    logic [1:0] port_up_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phy_bringup_seq #(
        .CLKS_PER_US(CPU), .RST_HOLD_US(HOLD), .STEP_US(STEP),
        .POLL_US(POLL), .POLL_MAX(PMAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_done_i(cfg_done_i),
        .phy_ready_i(phy_ready_i), .cfg_start_o(cfg_start_o), .por_n_o(por_n_o),
        .lane_rst_n_o(lane_rst_n_o), .synth_rst_n_o(synth_rst_n_o),
        .txpd_n_o(txpd_n_o), .rxpd_n_o(rxpd_n_o), .synthpd_n_o(synthpd_n_o),
        .tscale_ovr_o(tscale_ovr_o), .core_rst_n_o(core_rst_n_o),
        .mst_lp_req_o(mst_lp_req_o), .slv_lp_req_o(slv_lp_req_o),
        .busy_o(busy_o), .done_o(done_o), .port_up_o(port_up_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic bit seen(input int roff, input int erel);
        return (roff < 0) || (erel > roff);
    endfunction

    task automatic run_one(input int mask, input int roff, input int dly);
        int es, t_pd, t_p0, t_p1, t_cfg, t_cd, t_hr, t_ts, t_core, t_fin;
        int exp_rel, exp_up;
        bit hit;
        phy_ready_i = (roff < 0) ? mask[1:0] : 2'b00;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        es = cyc;
        // R2
        chk("R2", "controls low at start",
            {por_n_o, lane_rst_n_o, synth_rst_n_o, txpd_n_o, rxpd_n_o, synthpd_n_o}, 0);
        chk("R2", "core side low / busy", {tscale_ovr_o, core_rst_n_o, mst_lp_req_o, slv_lp_req_o, busy_o}, 1);
        // R11: restart attempt while busy
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (txpd_n_o != 2'b11) @(negedge clk);
        t_pd = cyc;
        chk("R3", "power-down release delay (R11 restart ignored)", t_pd - es, HOLD * CPU);
        chk("R3", "pd groups together, resets low",
            {rxpd_n_o, synthpd_n_o, por_n_o, lane_rst_n_o, synth_rst_n_o}, 10'b1111_000000);
        while (por_n_o[0] != 1'b1) @(negedge clk);
        t_p0 = cyc;
        chk("R4", "port0 por delay", t_p0 - t_pd, STEP * CPU);
        chk("R4", "port1 por still low", por_n_o[1], 0);
        while (por_n_o[1] != 1'b1) @(negedge clk);
        t_p1 = cyc;
        chk("R4", "port1 por stagger", t_p1 - t_p0, STEP * CPU);
        while (cfg_start_o != 1'b1) @(negedge clk);
        t_cfg = cyc;
        chk("R5", "cfg_start delay", t_cfg - t_p1, STEP * CPU);
        @(negedge clk);
        chk("R5", "cfg_start one cycle", cfg_start_o, 0);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk("R5", "hard resets held during handoff", {lane_rst_n_o, synth_rst_n_o}, 0);
        end
        cfg_done_i = 1'b1;
        t_cd = cyc + 1;
        @(negedge clk) cfg_done_i = 1'b0;
        while (lane_rst_n_o != 2'b11) @(negedge clk);
        t_hr = cyc;
        chk("R6", "hard reset release delay", t_hr - t_cd, STEP * CPU);
        chk("R6", "synth reset with lane reset", synth_rst_n_o, 3);
        while (!tscale_ovr_o) @(negedge clk);
        t_ts = cyc;
        chk("R7", "tscale delay", t_ts - t_hr, HOLD * CPU);
        chk("R7", "core still in reset with tscale", core_rst_n_o, 0);
        while (!core_rst_n_o) @(negedge clk);
        t_core = cyc;
        chk("R7", "core release one cycle after tscale", t_core - t_ts, 1);
        chk("R7", "low-power requests with core", {mst_lp_req_o, slv_lp_req_o}, 3);

        hit = 1'b0;
        exp_rel = 0;
        for (int k = 0; k < PMAX; k++) begin
            if (!hit) begin
                exp_rel = 2 + k * PER;
                if (mask == 3 && seen(roff, exp_rel)) hit = 1'b1;
            end
        end
        exp_up = seen(roff, exp_rel) ? mask : 0;

        fork
            begin
                if (roff >= 0) begin
                    while (cyc < t_core + roff) @(negedge clk);
                    phy_ready_i = mask[1:0];
                end
            end
            begin
                while (!done_o) @(negedge clk);
                t_fin = cyc;
                // R8 early exit / R9 timeout
                chk(hit ? "R8" : "R9", "done timing after core release", t_fin - t_core, exp_rel);
                chk("R9", "per-port result", port_up_o, exp_up);
                @(negedge clk);
                chk("R10", "done one cycle, idle after", {done_o, busy_o}, 0);
            end
        join
        phy_ready_i = 2'b00;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk("R1", "reset controls",
            {por_n_o, lane_rst_n_o, synth_rst_n_o, txpd_n_o, rxpd_n_o, synthpd_n_o}, 0);
        chk("R1", "reset misc",
            {cfg_start_o, tscale_ovr_o, core_rst_n_o, mst_lp_req_o, slv_lp_req_o, busy_o, done_o, port_up_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "idle after reset release", {busy_o, done_o}, 0);
        for (int m = 0; m < 4; m++) begin
            for (int r = -1; r <= 18; r++) begin
                run_one(m, r, (r + 1) % 4);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule